// File: doc/BRIEF.md
# Append-Only EPROM Programming Controller

This block holds the contents of a one-time-programmable byte memory and controls how it is written. The memory has a data area of 64 pages of 32 bytes and a separate status area. Every cell starts in the erased value FFh. A write clears bits and never sets them: the stored byte becomes the AND of its old value and the new byte. A host first loads a byte and its target address into a one-byte scratchpad. The write is committed only when a program strobe arrives while that byte is armed. The strobe stands in for the detection of the programming voltage.

The status area gates what can still be changed. One group of protect bytes locks whole data pages. A second group locks the per-page redirection bytes. A third group holds free flag bits that affect nothing. Status addresses outside the implemented groups read as FFh and ignore writes. After every program attempt the block returns the byte now stored at the target, together with a blocked flag, so the host can verify the write.

Controller states:
- `ST_IDLE`: waits for a request. A strobe here is ignored.
- `ST_ARMED`: a byte sits in the scratchpad. A strobe moves to `ST_PROG`. A new load replaces the scratchpad and stays in `ST_ARMED`. A read leaves for `ST_READ` and disarms.
- `ST_PROG`: decides the protection and writes the merged byte if the target is open.
- `ST_REPORT`: returns the resulting byte and the blocked flag, then goes to `ST_IDLE`.
- `ST_READ`: returns the addressed byte, then goes to `ST_IDLE`.

Top module: `eprom_append_ctrl`

## Requirements
- R1: After reset every data and status cell reads FFh, and `resp_valid` and `busy` are low.
- R2: A read request (`req_op` 00 for the data area, 01 for the status area) accepted while not busy raises `resp_valid` for one cycle, in the cycle after acceptance, with `resp_data` equal to the stored byte and `resp_blocked` low.
- R3: A committed write stores the old byte AND the scratchpad byte, so bits only ever go from 1 to 0.
- R4: A load request (`req_op` 10 for data, 11 for status) only arms the scratchpad and changes no cell. A later load replaces the armed byte. A read request disarms it, so a strobe that follows the read has no effect.
- R5: A `prog_strobe` pulse with no armed byte changes no cell and produces no response.
- R6: Bit k of status byte 000h+n covers data page 8n+k, and a 0 there blocks writes to every byte of that page. A blocked attempt reports `resp_blocked`=1 with the unchanged byte. Reads of that page still work, and other pages stay writable.
- R7: Bit k of status byte 020h+n covers redirection byte 100h+8n+k, and a 0 there blocks writes to that redirection byte. A blocked attempt reports the unchanged byte with `resp_blocked`=1.
- R8: Status addresses outside 000h–007h, 020h–027h, 040h–047h and 100h–13Fh read FFh. Writes there report `resp_blocked`=1 and store nothing.
- R9: The program response (`resp_valid` high with the resulting byte) appears exactly two cycles after the cycle in which the strobe is sampled in `ST_ARMED`.
- R10: The flag bytes at status 040h–047h are writable and have no effect on any protection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; returns all cells to FFh |
| req_valid | input | 1 | Request present; accepted when `busy` is low |
| req_op | input | 2 | 00 read data, 01 read status, 10 load data, 11 load status |
| req_addr | input | 11 | Byte address in the selected area |
| req_wdata | input | 8 | Byte placed into the scratchpad on a load |
| prog_strobe | input | 1 | Commit pulse for the armed scratchpad byte |
| busy | output | 1 | High while a read or program is in flight |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_data | output | 8 | Byte read, or byte stored after a program attempt |
| resp_blocked | output | 1 | High with a program response when the write was refused |

## Verification
A second write to the same byte must show AND-merging: a design that overwrites would return the new byte rather than the AND. Loading without a strobe, loading twice, and reading between load and strobe probe the arming rules: a loose design would commit early, keep the stale byte, or program after a read. Protection is exercised on a locked page next to an open one, and on a locked redirection byte next to an open one: a wrong bit-to-page mapping or a missing guard would alter the locked byte or refuse the neighbour. Writes to holes in the status map, and to the flag bytes, catch a decoder that aliases addresses or treats flags as protection.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

    localparam int unsigned ADDR_W = 11;

    localparam logic [ADDR_W-1:0] WPROT_BASE = 11'h000;
    localparam logic [ADDR_W-1:0] RPROT_BASE = 11'h020;
    localparam logic [ADDR_W-1:0] FLAG_BASE  = 11'h040;
    localparam logic [ADDR_W-1:0] REDIR_BASE = 11'h100;

    typedef enum logic [1:0] {
        OP_RD_DATA = 2'b00,
        OP_RD_STAT = 2'b01,
        OP_LD_DATA = 2'b10,
        OP_LD_STAT = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_PROG,
        ST_REPORT,
        ST_READ
    } state_e;

    typedef enum logic [2:0] {
        RG_WPROT,
        RG_RPROT,
        RG_FLAG,
        RG_REDIR,
        RG_NONE
    } region_e;

endpackage

// File: rtl/eprom_data_array.sv
module eprom_data_array #(
    parameter int unsigned DEPTH = 2048,
    parameter int unsigned AW    = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(DEPTH); i++) begin
                mem_q[i] <= 8'hFF;
            end
        end else if (we) begin
            mem_q[addr] <= wdata;
        end
    end

    assign rdata = mem_q[addr];

    AST_CLEAR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> ((wdata & ~mem_q[addr]) == 8'h00)); // R3

endmodule

// File: rtl/eprom_status_map.sv
module eprom_status_map
    import eprom_pkg::*;
#(
    parameter int unsigned PAGES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [7:0]        wdata,
    input  logic [$clog2(PAGES)-1:0] page_sel,
    output logic [7:0]        rdata,
    output region_e           region,
    output logic              page_open,
    output logic              redir_open
);

    localparam int unsigned PAGE_W     = $clog2(PAGES);
    localparam int unsigned PROT_BYTES = (PAGES + 7) / 8;
    localparam int unsigned PB_W       = (PROT_BYTES > 1) ? $clog2(PROT_BYTES) : 1;

    logic [7:0] wprot_q [PROT_BYTES];
    logic [7:0] rprot_q [PROT_BYTES];
    logic [7:0] flag_q  [PROT_BYTES];
    logic [7:0] redir_q [PAGES];

    logic [ADDR_W-1:0] off_wp, off_rp, off_fl, off_rd;
    logic [PB_W-1:0]   byte_idx;
    logic [PAGE_W-1:0] redir_idx;
    logic [PB_W-1:0]   pg_byte, rd_byte;

    always_comb begin
        off_wp = addr - WPROT_BASE;
        off_rp = addr - RPROT_BASE;
        off_fl = addr - FLAG_BASE;
        off_rd = addr - REDIR_BASE;
        if (addr >= WPROT_BASE && off_wp < ADDR_W'(PROT_BYTES)) begin
            region   = RG_WPROT;
            byte_idx = off_wp[PB_W-1:0];
        end else if (addr >= RPROT_BASE && off_rp < ADDR_W'(PROT_BYTES)) begin
            region   = RG_RPROT;
            byte_idx = off_rp[PB_W-1:0];
        end else if (addr >= FLAG_BASE && off_fl < ADDR_W'(PROT_BYTES)) begin
            region   = RG_FLAG;
            byte_idx = off_fl[PB_W-1:0];
        end else if (addr >= REDIR_BASE && off_rd < ADDR_W'(PAGES)) begin
            region   = RG_REDIR;
            byte_idx = '0;
        end else begin
            region   = RG_NONE;
            byte_idx = '0;
        end
        redir_idx = off_rd[PAGE_W-1:0];
    end

    always_comb begin
        unique case (region)
            RG_WPROT: rdata = wprot_q[byte_idx];
            RG_RPROT: rdata = rprot_q[byte_idx];
            RG_FLAG:  rdata = flag_q[byte_idx];
            RG_REDIR: rdata = redir_q[redir_idx];
            default:  rdata = 8'hFF;
        endcase
    end

    always_comb begin
        pg_byte    = PB_W'(page_sel >> 3);
        rd_byte    = PB_W'(redir_idx >> 3);
        page_open  = wprot_q[pg_byte][page_sel[2:0]];
        redir_open = rprot_q[rd_byte][redir_idx[2:0]];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(PROT_BYTES); i++) begin
                wprot_q[i] <= 8'hFF;
                rprot_q[i] <= 8'hFF;
                flag_q[i]  <= 8'hFF;
            end
            for (int j = 0; j < int'(PAGES); j++) begin
                redir_q[j] <= 8'hFF;
            end
        end else if (we) begin
            unique case (region)
                RG_WPROT: wprot_q[byte_idx]  <= wdata;
                RG_RPROT: rprot_q[byte_idx]  <= wdata;
                RG_FLAG:  flag_q[byte_idx]   <= wdata;
                RG_REDIR: redir_q[redir_idx] <= wdata;
                default:  ;
            endcase
        end
    end

    AST_HOLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (region != RG_NONE)); // R8

    AST_REDIR_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (we && region == RG_REDIR) |-> redir_open); // R7

    AST_STATUS_CLEAR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> ((wdata & ~rdata) == 8'h00)); // R3

endmodule

// File: rtl/eprom_wr_fsm.sv
module eprom_wr_fsm
    import eprom_pkg::*;
#(
    parameter int unsigned PAGES      = 64,
    parameter int unsigned PAGE_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_wdata,
    input  logic              prog_strobe,
    input  logic [7:0]        data_rd,
    input  logic [7:0]        stat_rd,
    input  region_e           stat_region,
    input  logic              page_open,
    input  logic              redir_open,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [$clog2(PAGES)-1:0] page_sel,
    output logic              data_we,
    output logic              stat_we,
    output logic [7:0]        merged,
    output logic              busy,
    output logic              resp_valid,
    output logic [7:0]        resp_data,
    output logic              resp_blocked
);

    localparam int unsigned DATA_BYTES = PAGES * PAGE_BYTES;
    localparam int unsigned DADDR_W    = $clog2(DATA_BYTES);
    localparam int unsigned OFS_W      = $clog2(PAGE_BYTES);

    state_e            state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic              space_q;
    logic [7:0]        scratch_q;
    logic              blocked_q;
    logic              accept;
    logic              blocked_c;
    logic [7:0]        old_byte;

    assign accept = req_valid && (state_q == ST_IDLE || state_q == ST_ARMED);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) state_d = req_op[1] ? ST_ARMED : ST_READ;
            end
            ST_ARMED: begin
                if (req_valid)        state_d = req_op[1] ? ST_ARMED : ST_READ;
                else if (prog_strobe) state_d = ST_PROG;
            end
            ST_PROG:   state_d = ST_REPORT;
            ST_REPORT: state_d = ST_IDLE;
            ST_READ:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q    <= '0;
            space_q   <= 1'b0;
            scratch_q <= 8'hFF;
            blocked_q <= 1'b0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                space_q <= req_op[0];
                if (req_op[1]) scratch_q <= req_wdata;
            end
            if (state_q == ST_PROG) blocked_q <= blocked_c;
        end
    end

    always_comb begin
        cur_addr  = addr_q;
        page_sel  = addr_q[DADDR_W-1:OFS_W];
        old_byte  = space_q ? stat_rd : data_rd;
        merged    = old_byte & scratch_q;
        if (space_q) begin
            blocked_c = (stat_region == RG_NONE) ||
                        (stat_region == RG_REDIR && !redir_open);
        end else begin
            blocked_c = !page_open;
        end
    end

    always_comb begin
        data_we      = 1'b0;
        stat_we      = 1'b0;
        busy         = 1'b0;
        resp_valid   = 1'b0;
        resp_data    = 8'h00;
        resp_blocked = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_ARMED: ;
            ST_PROG: begin
                busy    = 1'b1;
                data_we = !space_q && !blocked_c;
                stat_we = space_q && !blocked_c;
            end
            ST_REPORT: begin
                busy         = 1'b1;
                resp_valid   = 1'b1;
                resp_data    = old_byte;
                resp_blocked = blocked_q;
            end
            ST_READ: begin
                busy       = 1'b1;
                resp_valid = 1'b1;
                resp_data  = old_byte;
            end
            default: ;
        endcase
    end

    AST_READ_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && !req_op[1]) |=> (resp_valid && !resp_blocked)); // R2

    AST_PROG_FROM_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG) |-> ($past(state_q) == ST_ARMED && !$past(req_valid))); // R4

    AST_IDLE_STROBE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && prog_strobe && !req_valid) |=> (state_q == ST_IDLE && !resp_valid)); // R5

    AST_BLOCKED_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REPORT && resp_blocked) |-> (resp_data == $past(old_byte))); // R6

    AST_STROBE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && prog_strobe && !req_valid) |-> ##2 resp_valid); // R9

endmodule

// File: rtl/eprom_append_ctrl.sv
module eprom_append_ctrl
    import eprom_pkg::*;
#(
    parameter int unsigned PAGES      = 64,
    parameter int unsigned PAGE_BYTES = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [1:0]  req_op,
    input  logic [10:0] req_addr,
    input  logic [7:0]  req_wdata,
    input  logic        prog_strobe,
    output logic        busy,
    output logic        resp_valid,
    output logic [7:0]  resp_data,
    output logic        resp_blocked
);

    localparam int unsigned DATA_BYTES = PAGES * PAGE_BYTES;
    localparam int unsigned DADDR_W    = $clog2(DATA_BYTES);
    localparam int unsigned PAGE_W     = $clog2(PAGES);

    logic [ADDR_W-1:0] cur_addr;
    logic [PAGE_W-1:0] page_sel;
    logic              data_we, stat_we;
    logic [7:0]        merged, data_rd, stat_rd;
    region_e           stat_region;
    logic              page_open, redir_open;

    eprom_wr_fsm #(.PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_op       (req_op),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .prog_strobe  (prog_strobe),
        .data_rd      (data_rd),
        .stat_rd      (stat_rd),
        .stat_region  (stat_region),
        .page_open    (page_open),
        .redir_open   (redir_open),
        .cur_addr     (cur_addr),
        .page_sel     (page_sel),
        .data_we      (data_we),
        .stat_we      (stat_we),
        .merged       (merged),
        .busy         (busy),
        .resp_valid   (resp_valid),
        .resp_data    (resp_data),
        .resp_blocked (resp_blocked)
    );

    eprom_data_array #(.DEPTH(DATA_BYTES), .AW(DADDR_W)) u_data (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (cur_addr[DADDR_W-1:0]),
        .we    (data_we),
        .wdata (merged),
        .rdata (data_rd)
    );

    eprom_status_map #(.PAGES(PAGES)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (cur_addr),
        .we         (stat_we),
        .wdata      (merged),
        .page_sel   (page_sel),
        .rdata      (stat_rd),
        .region     (stat_region),
        .page_open  (page_open),
        .redir_open (redir_open)
    );

    AST_NO_DUAL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(data_we && stat_we)); // R3

    AST_FLAGS_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_we && stat_region == RG_FLAG) |=> ($stable(page_open) && $stable(redir_open))); // R10

endmodule

// File: tb/sim_eprom_append_ctrl.sv
module sim_eprom_append_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'b00;
    logic [10:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        prog_strobe = 1'b0;
    logic        busy, resp_valid, resp_blocked;
    logic [7:0]  resp_data;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    eprom_append_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .prog_strobe(prog_strobe),
        .busy(busy), .resp_valid(resp_valid), .resp_data(resp_data),
        .resp_blocked(resp_blocked)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_read(input logic st, input logic [10:0] a, output logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_op = {1'b0, st}; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 read response valid", 32'(resp_valid), 32'd1);
        d = resp_data;
    endtask

    task automatic do_load(input logic st, input logic [10:0] a, input logic [7:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_op = {1'b1, st}; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_prog(input logic st, input logic [10:0] a, input logic [7:0] wd,
                           output logic [7:0] d, output logic b);
        int lat;
        do_load(st, a, wd);
        prog_strobe = 1'b1;
        @(negedge clk);
        prog_strobe = 1'b0;
        lat = 1;
        while (!resp_valid && lat < 6) begin
            @(negedge clk);
            lat++;
        end
        chk("R9 program response latency", 32'(lat), 32'd2);
        d = resp_data;
        b = resp_blocked;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        chk("R1 resp_valid low in reset", 32'(resp_valid), 32'd0);
        chk("R1 busy low in reset", 32'(busy), 32'd0);
        @(negedge clk); rst_n = 1'b1;
        do_read(1'b0, 11'h000, d); chk("R1 data 000h erased", 32'(d), 32'hFF);
        do_read(1'b0, 11'h7FF, d); chk("R1 data 7FFh erased", 32'(d), 32'hFF);
        do_read(1'b1, 11'h000, d); chk("R1 status 000h erased", 32'(d), 32'hFF);
        do_read(1'b1, 11'h13F, d); chk("R1 status 13Fh erased", 32'(d), 32'hFF);
    endtask

    task automatic t_merge;
        logic [7:0] d; logic b;
        do_prog(1'b0, 11'h005, 8'hA5, d, b);
        chk("R3 first write result", 32'(d), 32'hA5);
        chk("R3 first write not blocked", 32'(b), 32'd0);
        do_read(1'b0, 11'h005, d); chk("R2 read back A5", 32'(d), 32'hA5);
        do_prog(1'b0, 11'h005, 8'h0F, d, b);
        chk("R3 second write is AND", 32'(d), 32'h05);
        do_prog(1'b0, 11'h005, 8'hFF, d, b);
        chk("R3 ones never restored", 32'(d), 32'h05);
    endtask

    task automatic t_arming;
        logic [7:0] d; logic b;
        do_load(1'b0, 11'h010, 8'h00);
        repeat (3) @(negedge clk);
        do_read(1'b0, 11'h010, d); chk("R4 load alone changes nothing", 32'(d), 32'hFF);
        @(negedge clk); prog_strobe = 1'b1;
        @(negedge clk); prog_strobe = 1'b0;
        chk("R4 strobe after read gives no response", 32'(resp_valid), 32'd0);
        do_read(1'b0, 11'h010, d); chk("R4 read disarmed the byte", 32'(d), 32'hFF);
        do_load(1'b0, 11'h011, 8'h00);
        do_prog(1'b0, 11'h011, 8'h3C, d, b);
        chk("R4 last load wins", 32'(d), 32'h3C);
    endtask

    task automatic t_idle_strobe;
        logic [7:0] d;
        @(negedge clk); prog_strobe = 1'b1;
        @(negedge clk); prog_strobe = 1'b0;
        chk("R5 no response to idle strobe", 32'(resp_valid), 32'd0);
        @(negedge clk);
        chk("R5 still no response", 32'(resp_valid), 32'd0);
        do_read(1'b0, 11'h005, d); chk("R5 byte untouched", 32'(d), 32'h05);
        do_read(1'b0, 11'h011, d); chk("R5 last target untouched", 32'(d), 32'h3C);
    endtask

    task automatic t_page_protect;
        logic [7:0] d; logic b;
        do_prog(1'b0, 11'h025, 8'hF7, d, b);
        chk("R6 page 1 open before lock", 32'(d), 32'hF7);
        do_prog(1'b1, 11'h000, 8'hFD, d, b);
        chk("R6 lock page 1", 32'(d), 32'hFD);
        do_prog(1'b0, 11'h025, 8'h00, d, b);
        chk("R6 locked write blocked", 32'(b), 32'd1);
        chk("R6 locked byte unchanged", 32'(d), 32'hF7);
        do_read(1'b0, 11'h025, d); chk("R6 locked page still readable", 32'(d), 32'hF7);
        do_prog(1'b0, 11'h045, 8'h12, d, b);
        chk("R6 page 2 still open", 32'(d), 32'h12);
        chk("R6 page 2 not blocked", 32'(b), 32'd0);
        do_prog(1'b1, 11'h001, 8'hFE, d, b);
        do_prog(1'b0, 11'h100, 8'h00, d, b);
        chk("R6 page 8 locked by byte 1 bit 0", 32'(b), 32'd1);
    endtask

    task automatic t_redir_protect;
        logic [7:0] d; logic b;
        do_prog(1'b1, 11'h102, 8'hFD, d, b);
        chk("R7 redirection byte writable", 32'(d), 32'hFD);
        do_prog(1'b1, 11'h020, 8'hFB, d, b);
        do_prog(1'b1, 11'h102, 8'h00, d, b);
        chk("R7 protected redirection blocked", 32'(b), 32'd1);
        chk("R7 protected redirection unchanged", 32'(d), 32'hFD);
        do_prog(1'b1, 11'h103, 8'hF0, d, b);
        chk("R7 neighbour redirection open", 32'(d), 32'hF0);
    endtask

    task automatic t_holes;
        logic [7:0] d; logic b;
        do_prog(1'b1, 11'h008, 8'h00, d, b);
        chk("R8 hole write blocked", 32'(b), 32'd1);
        chk("R8 hole reports FF", 32'(d), 32'hFF);
        do_read(1'b1, 11'h008, d); chk("R8 hole reads FF", 32'(d), 32'hFF);
        do_prog(1'b1, 11'h140, 8'h00, d, b);
        chk("R8 hole above redirection blocked", 32'(b), 32'd1);
        do_read(1'b1, 11'h7FF, d); chk("R8 top hole reads FF", 32'(d), 32'hFF);
        do_read(1'b1, 11'h000, d); chk("R8 hole write did not alias", 32'(d), 32'hFD);
    endtask

    task automatic t_flags;
        logic [7:0] d; logic b;
        do_prog(1'b1, 11'h040, 8'h00, d, b);
        chk("R10 flag byte written", 32'(d), 32'h00);
        chk("R10 flag write not blocked", 32'(b), 32'd0);
        do_prog(1'b0, 11'h001, 8'h77, d, b);
        chk("R10 page 0 unaffected by flags", 32'(d), 32'h77);
        do_prog(1'b1, 11'h101, 8'h7F, d, b);
        chk("R10 redirection 1 unaffected by flags", 32'(d), 32'h7F);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_merge();
        t_arming();
        t_idle_strobe();
        t_page_protect();
        t_redir_protect();
        t_holes();
        t_flags();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule